// File: doc/BRIEF.md
# Six-Channel DMA Bus Arbiter with Selectable Priority

This block decides which of six DMA channels may use a shared bus. Every cycle it looks at the channels that are requesting and allowed to run, and it picks at most one of them. The pick is held in a register and offered to the bus. The bus accepts it by raising a ready signal. A control bit selects the scheme. In fixed priority the lowest-numbered eligible channel always wins. In round robin the turn moves upward through the channel numbers after each accepted grant.

Eligibility depends on several inputs. The whole controller must be enabled. Each channel has its own enable. The channels also fall into two power-down groups: channels 0-3 form one group and channels 4-5 form the other. Each group has its own disable bit. Address generation, counting and data movement are done elsewhere. The arbiter only produces a one-hot grant, a valid flag and the number of the granted channel.

Top module: `chan_bus_arbiter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the grant is cleared: `gnt`=0, `gnt_vld`=0 and `gnt_id`=0. The round-robin start point also returns to channel 0, so the first round-robin pick after reset goes to the lowest-numbered eligible channel.
- R2: If `ctl_en` is 0 at a rising edge, `gnt_vld` and `gnt` are 0 after that edge.
- R3: A channel can be granted only if, in the cycle its grant is loaded, both its `ch_req` bit and its `ch_en` bit are 1.
- R4: Bit 0 of `grp_off` removes channels 0-3 from arbitration, and bit 1 removes channels 4-5. With both bits set, no grant is issued.
- R5: With `sched_rr`=0 (fixed priority), a new grant goes to the lowest-numbered eligible channel, whatever was granted before.
- R6: With `sched_rr`=1 (round robin), after channel k is accepted the next search starts at k+1 and wraps from 5 to 0. The first eligible channel found from that point wins.
- R7: The round-robin start point moves only when a grant is accepted (`gnt_vld`=1 and `bus_rdy`=1 at the same edge). A grant that is cleared before it is accepted leaves the start point unchanged.
- R8: When `sched_rr` changes from 0 to 1, the start point returns to channel 0 for the pick made at that edge.
- R9: While `gnt_vld`=1 and `bus_rdy`=0, with `ctl_en`=1, the grant outputs keep their values. A new winner is loaded only when there is no grant or the current grant is accepted.
- R10: A grant is loaded one rising edge after the inputs that select it. When `gnt_vld`=1, `gnt` is one-hot and bit `gnt_id` is the set bit. When `gnt_vld`=0, `gnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_en | input | 1 | Controller enable |
| sched_rr | input | 1 | Scheme select: 1 selects round robin, 0 selects fixed priority |
| grp_off | input | 2 | Group disable bits: bit 0 covers channels 0-3, bit 1 covers channels 4-5 |
| ch_en | input | 6 | Per-channel enable |
| ch_req | input | 6 | Per-channel request |
| bus_rdy | input | 1 | The bus accepts the current grant |
| gnt | output | 6 | One-hot grant |
| gnt_vld | output | 1 | A grant is present |
| gnt_id | output | 3 | Number of the granted channel, 0 when there is no grant |

## Verification
All results are due one rising edge after the inputs that cause them. This covers the new grant, its clearing when the controller is disabled, and the move of the round-robin start point, which is seen in the pick at the following accept. The bench changes inputs on the falling edge. It compares the outputs 1 ns after the next rising edge against its own cycle model of the requirements. The directed tasks also compare against explicitly expected channel numbers. For the hold and pointer cases, the bench keeps `bus_rdy` low over several edges. It then checks which channel is granted after the grant is accepted, or after it is dropped without being accepted.

// File: rtl/chan_arb_pkg.sv
// Shared definitions for the DMA bus arbiter.
// Assumes: channel numbers fit in the width derived by the users of this package.
package chan_arb_pkg;

    // Scheme selected by the sched_rr input
    typedef enum logic {
        SCHED_FIXED  = 1'b0,
        SCHED_ROTATE = 1'b1
    } sched_e;

endpackage

// File: rtl/arb_gate.sv
// Eligibility gating: combines each request with the controller enable,
// the channel's own enable and its power-down group bit.
// Assumes: channels below GRP0_CH belong to group 0, the rest to group 1.
module arb_gate #(
    parameter int unsigned NUM_CH  = 6,
    parameter int unsigned GRP0_CH = 4
) (
    input  logic              ctl_en,
    input  logic [1:0]        grp_off,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic [NUM_CH-1:0] ch_req,
    output logic [NUM_CH-1:0] elig
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int unsigned GRP = (i < GRP0_CH) ? 0 : 1;
        // Channel i may compete only when every enable condition holds
        assign elig[i] = ctl_en & ch_en[i] & ch_req[i] & ~grp_off[GRP];
    end

endmodule

// File: rtl/arb_pick.sv
// Circular first-one search: finds the first eligible channel at or after
// the start index, wrapping past the top channel back to 0.
// Assumes: start < NUM_CH. A start of 0 gives fixed lowest-number priority.
module arb_pick #(
    parameter int unsigned NUM_CH = 6,
    localparam int unsigned IDW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] mask,
    input  logic [IDW-1:0]    start,
    output logic [NUM_CH-1:0] win,
    output logic [IDW-1:0]    win_id,
    output logic              win_any
);

    // Scan from the farthest offset down, so the nearest eligible channel wins
    always_comb begin
        win     = '0;
        win_id  = '0;
        win_any = 1'b0;
        for (int off = NUM_CH - 1; off >= 0; off--) begin
            int k;
            k = int'(start) + off;
            if (k >= int'(NUM_CH)) k = k - int'(NUM_CH);
            if (mask[k]) begin
                win     = '0;
                win[k]  = 1'b1;
                win_id  = IDW'(k);
                win_any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/arb_ptr_ctrl.sv
// Round-robin pointer and scheme tracking. Picks the search start for this
// cycle and keeps the start point for later picks.
// Assumes: accept is high only while a grant is held; cur_id is its channel.
module arb_ptr_ctrl #(
    parameter int unsigned NUM_CH = 6,
    localparam int unsigned IDW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sched_rr,
    input  logic           accept,
    input  logic [IDW-1:0] cur_id,
    output logic [IDW-1:0] start
);
    import chan_arb_pkg::*;

    sched_e         mode_q;
    logic [IDW-1:0] ptr_q;
    logic [IDW-1:0] after_cur;
    logic           entering;

    // Channel after the accepted one, wrapping at the top
    assign after_cur = (cur_id == IDW'(NUM_CH - 1)) ? '0 : cur_id + 1'b1;
    assign entering  = sched_rr & (mode_q == SCHED_FIXED);

    // Start index for this cycle's pick
    always_comb begin
        if (!sched_rr || entering) start = '0;
        else if (accept)           start = after_cur;
        else                       start = ptr_q;
    end

    // Keep the previous scheme and the round-robin start point
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= SCHED_FIXED;
            ptr_q  <= '0;
        end else begin
            mode_q <= sched_rr ? SCHED_ROTATE : SCHED_FIXED;
            if (entering)               ptr_q <= '0;
            else if (sched_rr && accept) ptr_q <= after_cur;
        end
    end

endmodule

// File: rtl/chan_bus_arbiter.sv
// Top level of the six-channel DMA bus arbiter. Holds the registered grant
// and offers it to the bus until bus_rdy accepts it.
// Assumes: bus_rdy is meaningful only while gnt_vld is high.
module chan_bus_arbiter #(
    parameter int unsigned NUM_CH  = 6,
    parameter int unsigned GRP0_CH = 4,
    localparam int unsigned IDW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_en,
    input  logic              sched_rr,
    input  logic [1:0]        grp_off,
    input  logic [NUM_CH-1:0] ch_en,
    input  logic [NUM_CH-1:0] ch_req,
    input  logic              bus_rdy,
    output logic [NUM_CH-1:0] gnt,
    output logic              gnt_vld,
    output logic [IDW-1:0]    gnt_id
);

    logic [NUM_CH-1:0] elig;
    logic [NUM_CH-1:0] win;
    logic [IDW-1:0]    win_id;
    logic              win_any;
    logic [IDW-1:0]    start;
    logic              accept;

    assign accept = gnt_vld & bus_rdy;

    arb_gate #(.NUM_CH(NUM_CH), .GRP0_CH(GRP0_CH)) u_gate (
        .ctl_en  (ctl_en),
        .grp_off (grp_off),
        .ch_en   (ch_en),
        .ch_req  (ch_req),
        .elig    (elig)
    );

    arb_ptr_ctrl #(.NUM_CH(NUM_CH)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .sched_rr (sched_rr),
        .accept   (accept),
        .cur_id   (gnt_id),
        .start    (start)
    );

    arb_pick #(.NUM_CH(NUM_CH)) u_pick (
        .mask    (elig),
        .start   (start),
        .win     (win),
        .win_id  (win_id),
        .win_any (win_any)
    );

    // Grant register: clear when disabled, hold until accepted, else load
    always_ff @(posedge clk) begin
        if (!rst_n || !ctl_en) begin
            gnt     <= '0;
            gnt_vld <= 1'b0;
            gnt_id  <= '0;
        end else if (!gnt_vld || bus_rdy) begin
            gnt     <= win;
            gnt_vld <= win_any;
            gnt_id  <= win_id;
        end
    end

endmodule

// File: rtl/chan_bus_arbiter_chk.sv
// Property checker for the arbiter, attached to every instance by bind.
// Assumes: the same parameters as the instance it observes.
module chan_bus_arbiter_chk #(
    parameter int unsigned NUM_CH  = 6,
    parameter int unsigned GRP0_CH = 4,
    localparam int unsigned IDW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_en,
    input logic              sched_rr,
    input logic [1:0]        grp_off,
    input logic [NUM_CH-1:0] ch_en,
    input logic [NUM_CH-1:0] ch_req,
    input logic              bus_rdy,
    input logic [NUM_CH-1:0] gnt,
    input logic              gnt_vld,
    input logic [IDW-1:0]    gnt_id
);

    localparam logic [NUM_CH-1:0] LOW_GRP = {{(NUM_CH-GRP0_CH){1'b0}}, {GRP0_CH{1'b1}}};

    logic [NUM_CH-1:0] avail;
    logic              loading;

    assign avail = ch_req & ch_en
                 & ~(grp_off[0] ? LOW_GRP : '0)
                 & ~(grp_off[1] ? ~LOW_GRP : '0);
    assign loading = ctl_en && (!gnt_vld || bus_rdy);

    // R10
    gnt_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld ? ($onehot(gnt) && gnt[gnt_id]) : (gnt == '0));

    // R2
    ctl_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> (!gnt_vld && gnt == '0));

    // R9
    hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vld && !bus_rdy && ctl_en) |=> (gnt_vld && $stable(gnt) && $stable(gnt_id)));

    // R3
    eligible_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loading |=> ((gnt & ~$past(avail)) == '0));

    // R5
    fixed_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loading && !sched_rr) |=> (gnt == $past(avail & (~avail + 1'b1))));

    // R4
    grp_low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loading && grp_off[0]) |=> ((gnt & LOW_GRP) == '0));

    // R4
    grp_high_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loading && grp_off[1]) |=> ((gnt & ~LOW_GRP) == '0));

endmodule

bind chan_bus_arbiter chan_bus_arbiter_chk #(.NUM_CH(NUM_CH), .GRP0_CH(GRP0_CH)) u_chk (.*);

// File: tb/chan_bus_arbiter_tb.sv
module chan_bus_arbiter_tb;

    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ctl_en = 1'b0;
    logic         sched_rr = 1'b0;
    logic [1:0]   grp_off = 2'b00;
    logic [N-1:0] ch_en = '0;
    logic [N-1:0] ch_req = '0;
    logic         bus_rdy = 1'b0;
    logic [N-1:0] gnt;
    logic         gnt_vld;
    logic [2:0]   gnt_id;

    int n_tests = 0;
    int n_fail  = 0;

    // bench model state
    bit m_vld;
    int m_id;
    int m_ptr;
    bit m_mode;

    chan_bus_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .sched_rr(sched_rr),
        .grp_off(grp_off), .ch_en(ch_en), .ch_req(ch_req), .bus_rdy(bus_rdy),
        .gnt(gnt), .gnt_vld(gnt_vld), .gnt_id(gnt_id)
    );

    always #4 clk = ~clk;

    function automatic int pick(input logic [N-1:0] m, input int s);
        for (int off = 0; off < N; off++) begin
            if (m[(s + off) % N]) return (s + off) % N;
        end
        return -1;
    endfunction

    // advance the model by one rising edge using the present inputs
    task automatic model_edge();
        logic [N-1:0] el;
        bit acc, ent;
        int st, w;
        if (!rst_n) begin
            m_vld = 0; m_id = 0; m_ptr = 0; m_mode = 0;
            return;
        end
        for (int i = 0; i < N; i++)
            el[i] = ctl_en & ch_en[i] & ch_req[i] & ~grp_off[(i < 4) ? 0 : 1];
        acc = m_vld & bus_rdy;
        ent = sched_rr & !m_mode;
        st  = (!sched_rr || ent) ? 0 : (acc ? (m_id + 1) % N : m_ptr);
        if (ent) m_ptr = 0;
        else if (sched_rr && acc) m_ptr = (m_id + 1) % N;
        if (!ctl_en) begin
            m_vld = 0; m_id = 0;
        end else if (!(m_vld && !bus_rdy)) begin
            w = pick(el, st);
            m_vld = (w >= 0);
            m_id  = (w >= 0) ? w : 0;
        end
        m_mode = sched_rr;
    endtask

    // one cycle: inputs already set at falling edge; compare after the rising edge
    task automatic step(input string tag);
        logic [N-1:0] eg;
        model_edge();
        @(posedge clk);
        #1;
        eg = m_vld ? (N'(1) << m_id) : '0;
        n_tests++;
        if (gnt_vld !== m_vld || gnt !== eg || gnt_id !== 3'(m_id)) begin
            n_fail++;
            $display("FAIL %s: vld=%0b gnt=%b id=%0d expected vld=%0b gnt=%b id=%0d",
                     tag, gnt_vld, gnt, gnt_id, m_vld, eg, m_id);
        end
        @(negedge clk);
    endtask

    // explicit expectation derived by hand from the requirement
    task automatic expect_grant(input string tag, input bit v, input int id);
        n_tests++;
        if (gnt_vld !== v || (v && gnt_id !== 3'(id))) begin
            n_fail++;
            $display("FAIL %s: vld=%0b id=%0d expected vld=%0b id=%0d", tag, gnt_vld, gnt_id, v, id);
        end
    endtask

    task automatic idle();
        ctl_en = 0; sched_rr = 0; grp_off = 0; bus_rdy = 1; ch_req = '0; ch_en = '1;
        step("idle");
        ctl_en = 1;
    endtask

    task automatic t_reset();
        rst_n = 0;
        step("R1 reset");
        step("R1 reset");
        expect_grant("R1 reset clear", 0, 0);
        rst_n = 1; ctl_en = 1; ch_en = '1; sched_rr = 1; ch_req = 6'b110110; bus_rdy = 1;
        step("R1 first rr");
        expect_grant("R1 first rr lowest", 1, 1);
    endtask

    task automatic t_fixed();
        idle();
        ch_req = 6'b101100;
        step("R5 fixed");  expect_grant("R5 fixed a", 1, 2);
        step("R5 fixed");  expect_grant("R5 fixed again", 1, 2);
        ch_req = 6'b100001;
        step("R5 fixed");  expect_grant("R5 fixed b", 1, 0);
    endtask

    task automatic t_enable();
        idle();
        ch_req = '1; ch_en = 6'b010000;
        step("R3 chan en"); expect_grant("R3 only ch4 enabled", 1, 4);
        ch_req = 6'b001111; ch_en = 6'b110000;
        step("R3 chan en"); expect_grant("R3 enabled not requesting", 0, 0);
    endtask

    task automatic t_groups();
        idle();
        ch_req = '1;
        grp_off = 2'b01; step("R4 grp0 off"); expect_grant("R4 grp0 off", 1, 4);
        grp_off = 2'b10; step("R4 grp1 off"); expect_grant("R4 grp1 off", 1, 0);
        grp_off = 2'b11; step("R4 both off"); expect_grant("R4 both off", 0, 0);
    endtask

    task automatic t_global();
        idle();
        ch_req = '1; bus_rdy = 0;
        step("R2 on");  expect_grant("R2 grant before", 1, 0);
        ctl_en = 0;
        step("R2 off"); expect_grant("R2 disabled", 0, 0);
    endtask

    task automatic t_rotate();
        idle();
        sched_rr = 1; ch_req = '1;
        for (int k = 0; k <= N; k++) begin
            step("R6 rotate");
            expect_grant("R6 rotate order", 1, k % N);
        end
        ch_req = 6'b000101;
        step("R6 skip"); expect_grant("R6 wrap skip", 1, 2);
        step("R6 skip"); expect_grant("R6 wrap to 0", 1, 0);
    endtask

    task automatic t_hold();
        idle();
        sched_rr = 1; ch_req = '1; bus_rdy = 0;
        step("R9 load"); expect_grant("R9 load", 1, 0);
        for (int k = 0; k < 3; k++) begin
            ch_req = 6'b111110;
            step("R9 hold"); expect_grant("R9 held", 1, 0);
        end
        bus_rdy = 1; ch_req = '1;
        step("R7 accept"); expect_grant("R7 after accept", 1, 1);
        ch_req = 6'b111011;
        step("R7 accept"); expect_grant("R7 skip disabled", 1, 3);
        bus_rdy = 0;
        step("R9 hold");
        ctl_en = 0;
        step("R7 drop");   expect_grant("R7 dropped", 0, 0);
        ctl_en = 1; bus_rdy = 1;
        step("R7 reload"); expect_grant("R7 pointer kept", 1, 3);
    endtask

    task automatic t_enter();
        idle();
        sched_rr = 1; ch_req = '1;
        step("R8 rr"); step("R8 rr"); step("R8 rr");
        expect_grant("R8 rr at 2", 1, 2);
        sched_rr = 0;
        step("R8 fixed"); expect_grant("R8 fixed lowest", 1, 0);
        sched_rr = 1;
        step("R8 reenter"); expect_grant("R8 reenter lowest", 1, 0);
        step("R8 next"); expect_grant("R8 next after reenter", 1, 1);
    endtask

    task automatic t_random();
        logic [15:0] lf = 16'hACE1;
        idle();
        for (int k = 0; k < 400; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            ch_req  = lf[5:0];
            bus_rdy = lf[7] | lf[8];
            if (lf[15:12] == 4'h0) sched_rr = ~sched_rr;
            ch_en   = (lf[11:9] == 3'd0) ? lf[13:8] : '1;
            grp_off = (lf[14:11] == 4'hF) ? lf[2:1] : 2'b00;
            ctl_en  = (lf[10:6] != 5'd0);
            step("R10 random");
        end
    endtask

    initial begin
        #150000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_fixed();
        t_enable();
        t_groups();
        t_global();
        t_rotate();
        t_hold();
        t_enter();
        t_random();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule